// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block keeps the control state of one USB device endpoint and picks the reply for every token the serial engine hands it. Software drives it through write-one strobes (force NAK on, force NAK off, force the even/DATA0 or odd/DATA1 value) and through a configuration write that loads the halt (STALL) bit, the snoop bit and the transfer type. The packet engine presents one token per cycle, together with the FIFO state, the received data PID and an error flag. One cycle later the block raises exactly one response pulse: ACK, NAK, STALL, a zero-length-packet request, a send-data request, or nothing.

The reply comes from a Moore state machine. It rests in IDLE and moves, for each token, to one of ACK_KEEP (ACK, data written to memory), ACK_DROP (ACK, data thrown away after a PID mismatch), NAK, STALL, ZLP, SEND, ISO_KEEP (isochronous data stored, no handshake) or SILENT (token ignored). Each response state lasts one cycle. It returns to IDLE when no token follows, or goes straight to the next response state when one does. A combinational decision stage computes the next state from the token and the endpoint registers. That stage also requests the data PID toggle and flags the SETUP event that makes the hardware set NAK.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After reset, NAK, STALL and snoop are clear, the type is control, the expected PID is DATA0 (exp_pid=0), frame_odd is 0 and all response outputs are 0.
- R2: set_nak=1 sets NAK and clr_nak=1 clears it. If both are 1 in the same cycle, NAK ends up set. A strobe held at 0 changes nothing.
- R3: The endpoint sets NAK on its own in the cycle after xfer_done=1 and after a SETUP token (tok_kind=01). A SETUP also loads the expected PID with DATA1.
- R4: A SETUP token is always answered with ACK plus store_data, whatever the NAK, STALL and global NAK inputs are.
- R5: On bulk (type 10) and interrupt (type 11) endpoints, a set STALL bit answers OUT (10) and IN (11) tokens with STALL, ahead of the endpoint NAK and both global NAK inputs. STALL changes only on a configuration write. On control (00) and isochronous (01) endpoints the STALL bit has no effect.
- R6: An OUT token under endpoint NAK or glob_out_nak is answered NAK on non-isochronous endpoints even when fifo_space=1. On isochronous endpoints it is dropped silently.
- R7: An IN token under NAK gets NAK on non-isochronous endpoints, even with tx_avail=1, and a zero-length-packet request on isochronous endpoints. glob_np_in_nak acts like NAK only on control and bulk IN tokens.
- R8: On control, bulk and interrupt endpoints, an OUT packet whose rx_pid matches exp_pid gets ACK plus store_data, and the expected PID toggles. A mismatching packet gets ACK without store_data, and the expected PID does not change.
- R9: With snoop off, an OUT packet with pkt_err=1 gets no response and changes no state. With snoop on, the error flag is ignored.
- R10: set_odd_d1 and set_even_d0 force exp_pid to 1 or 0 on bulk and interrupt endpoints. On isochronous endpoints they force frame_odd to 1 or 0 instead. On control endpoints they have no effect.
- R11: A non-isochronous OUT without fifo_space gets NAK. An IN with tx_avail gets send_data. A non-isochronous IN without data gets NAK, and an isochronous one gets a zero-length-packet request. An isochronous OUT with space and no error gets store_data with no handshake.
- R12: nak_status equals the endpoint NAK bit, whether software or hardware set it.
- R13: The response to a token taken at a clock edge is visible for exactly the following cycle. At most one of the handshake outputs is high at a time, and back-to-back tokens give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load cfg_stall, cfg_snoop, cfg_type |
| cfg_stall | input | 1 | Halt bit value |
| cfg_snoop | input | 1 | Snoop bit value |
| cfg_type | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| set_nak | input | 1 | Write-one: set NAK |
| clr_nak | input | 1 | Write-one: clear NAK |
| set_even_d0 | input | 1 | Write-one: DATA0 or even frame |
| set_odd_d1 | input | 1 | Write-one: DATA1 or odd frame |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | 01 SETUP, 10 OUT, 11 IN |
| fifo_space | input | 1 | Receive FIFO can take a packet |
| tx_avail | input | 1 | Transmit FIFO holds a packet |
| rx_pid | input | 1 | Received data PID (0 DATA0, 1 DATA1) |
| pkt_err | input | 1 | Received packet is corrupt |
| xfer_done | input | 1 | Transfer-complete event |
| glob_np_in_nak | input | 1 | Global non-periodic IN NAK |
| glob_out_nak | input | 1 | Global OUT NAK |
| hs_ack | output | 1 | Send ACK |
| hs_nak | output | 1 | Send NAK |
| hs_stall | output | 1 | Send STALL |
| zlp_req | output | 1 | Send a zero-length data packet |
| send_data | output | 1 | Send the queued IN packet |
| store_data | output | 1 | Commit received data to memory |
| exp_pid | output | 1 | Expected data PID |
| frame_odd | output | 1 | Isochronous frame parity |
| nak_status | output | 1 | NAK handshakes are being sent |

## Verification
The bench targets the priority chain. It gives STALL together with local and global NAKs, and a design with the order swapped would answer NAK on a halted endpoint. It sends SETUP to a halted and NAKed endpoint, where a careless decoder would refuse it. It sets and clears NAK in the same cycle, which exposes a reversed strobe priority. It also checks that the force strobes and the STALL bit do nothing on the types they do not apply to: a wrong design would change the PID on a control endpoint or stall an isochronous one. Repeated and mismatched PIDs, corrupt packets with and without snoop, and isochronous IN under NAK catch a missing toggle, a toggle on a duplicate packet, or silence where a zero-length packet is due.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_ISO  = 2'b01,
        EP_BULK = 2'b10,
        EP_INTR = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'b00,
        TK_SETUP = 2'b01,
        TK_OUT   = 2'b10,
        TK_IN    = 2'b11
    } tok_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK_KEEP,
        ST_ACK_DROP,
        ST_NAK,
        ST_STALL,
        ST_ZLP,
        ST_SEND,
        ST_ISO_KEEP,
        ST_SILENT
    } hs_state_e;

    typedef struct packed {
        logic ack;
        logic nak;
        logic stall;
        logic zlp;
        logic send;
        logic store;
    } hs_resp_t;

    localparam hs_resp_t RESP_NONE = '0;

endpackage

// File: rtl/ep_hs_regs.sv
module ep_hs_regs
    import ep_hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  logic     cfg_stall,
    input  logic     cfg_snoop,
    input  ep_kind_e cfg_type,
    input  logic     set_nak,
    input  logic     clr_nak,
    input  logic     set_even_d0,
    input  logic     set_odd_d1,
    input  logic     hw_nak_set,
    input  logic     setup_seen,
    input  logic     pid_toggle,
    output logic     nak_q,
    output logic     stall_q,
    output logic     snoop_q,
    output ep_kind_e type_q,
    output logic     pid_q,
    output logic     odd_q
);

    logic pid_forcible;
    logic par_forcible;

    always_comb begin
        pid_forcible = (type_q == EP_BULK) || (type_q == EP_INTR);
        par_forcible = (type_q == EP_ISO);
    end

    // configuration bits: only a configuration write moves them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            snoop_q <= 1'b0;
            type_q  <= EP_CTRL;
        end else if (cfg_we) begin
            stall_q <= cfg_stall;
            snoop_q <= cfg_snoop;
            type_q  <= cfg_type;
        end
    end

    // NAK: any set source beats the clear strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nak_q <= 1'b0;
        end else if (set_nak || hw_nak_set) begin
            nak_q <= 1'b1;
        end else if (clr_nak) begin
            nak_q <= 1'b0;
        end
    end

    // expected data PID
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q <= 1'b0;
        end else if (setup_seen) begin
            pid_q <= 1'b1;
        end else if (pid_forcible && set_odd_d1) begin
            pid_q <= 1'b1;
        end else if (pid_forcible && set_even_d0) begin
            pid_q <= 1'b0;
        end else if (pid_toggle) begin
            pid_q <= ~pid_q;
        end
    end

    // isochronous frame parity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
        end else if (par_forcible && set_odd_d1) begin
            odd_q <= 1'b1;
        end else if (par_forcible && set_even_d0) begin
            odd_q <= 1'b0;
        end
    end

    p_stall_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && !cfg_we) |=> stall_q)
        else $error("R5: STALL dropped without a configuration write");

    p_nak_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_nak |=> nak_q)
        else $error("R2: set strobe did not set NAK");

    p_nak_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_nak && !set_nak && !hw_nak_set) |=> !nak_q)
        else $error("R2: clear strobe did not clear NAK");

    p_ctrl_pid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q == EP_CTRL && !setup_seen && !pid_toggle) |=> $stable(pid_q))
        else $error("R10: control endpoint PID moved by a strobe");

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
    import ep_hs_pkg::*;
(
    input  logic      tok_valid,
    input  tok_kind_e tok_kind,
    input  ep_kind_e  ep_type,
    input  logic      nak,
    input  logic      stall,
    input  logic      snoop,
    input  logic      fifo_space,
    input  logic      tx_avail,
    input  logic      rx_pid,
    input  logic      pkt_err,
    input  logic      exp_pid,
    input  logic      glob_np_in_nak,
    input  logic      glob_out_nak,
    output hs_state_e nxt_st,
    output logic      pid_toggle,
    output logic      setup_seen
);

    logic is_iso;
    logic stall_live;
    logic out_block;
    logic in_block;
    logic bad_pkt;

    always_comb begin
        is_iso     = (ep_type == EP_ISO);
        stall_live = stall && ((ep_type == EP_BULK) || (ep_type == EP_INTR));
        out_block  = nak || glob_out_nak;
        in_block   = nak || (glob_np_in_nak &&
                             ((ep_type == EP_CTRL) || (ep_type == EP_BULK)));
        bad_pkt    = pkt_err && !snoop;
    end

    always_comb begin
        nxt_st     = ST_IDLE;
        pid_toggle = 1'b0;
        setup_seen = 1'b0;
        if (tok_valid) begin
            unique case (tok_kind)
                TK_SETUP: begin
                    nxt_st     = ST_ACK_KEEP;
                    setup_seen = 1'b1;
                end
                TK_OUT: begin
                    if (is_iso) begin
                        if (out_block || bad_pkt || !fifo_space) begin
                            nxt_st = ST_SILENT;
                        end else begin
                            nxt_st = ST_ISO_KEEP;
                        end
                    end else if (stall_live) begin
                        nxt_st = ST_STALL;
                    end else if (out_block) begin
                        nxt_st = ST_NAK;
                    end else if (bad_pkt) begin
                        nxt_st = ST_SILENT;
                    end else if (!fifo_space) begin
                        nxt_st = ST_NAK;
                    end else if (rx_pid == exp_pid) begin
                        nxt_st     = ST_ACK_KEEP;
                        pid_toggle = 1'b1;
                    end else begin
                        nxt_st = ST_ACK_DROP;
                    end
                end
                TK_IN: begin
                    if (stall_live) begin
                        nxt_st = ST_STALL;
                    end else if (is_iso) begin
                        nxt_st = (!nak && tx_avail) ? ST_SEND : ST_ZLP;
                    end else if (in_block || !tx_avail) begin
                        nxt_st = ST_NAK;
                    end else begin
                        nxt_st = ST_SEND;
                    end
                end
                default: nxt_st = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ep_hs_fsm.sv
module ep_hs_fsm
    import ep_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hs_state_e nxt_st,
    output hs_resp_t  resp
);

    hs_state_e st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= nxt_st;
        end
    end

    always_comb begin
        resp = RESP_NONE;
        unique case (st_q)
            ST_IDLE:     resp = RESP_NONE;
            ST_ACK_KEEP: begin resp.ack = 1'b1; resp.store = 1'b1; end
            ST_ACK_DROP: resp.ack   = 1'b1;
            ST_NAK:      resp.nak   = 1'b1;
            ST_STALL:    resp.stall = 1'b1;
            ST_ZLP:      resp.zlp   = 1'b1;
            ST_SEND:     resp.send  = 1'b1;
            ST_ISO_KEEP: resp.store = 1'b1;
            ST_SILENT:   resp = RESP_NONE;
            default:     resp = RESP_NONE;
        endcase
    end

    p_one_hs_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp.ack, resp.nak, resp.stall, resp.zlp, resp.send}))
        else $error("R13: more than one handshake at once");

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_st == ST_IDLE) |=> (resp == RESP_NONE))
        else $error("R13: response outside its cycle");

endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
    import ep_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_stall,
    input  logic       cfg_snoop,
    input  logic [1:0] cfg_type,
    input  logic       set_nak,
    input  logic       clr_nak,
    input  logic       set_even_d0,
    input  logic       set_odd_d1,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       fifo_space,
    input  logic       tx_avail,
    input  logic       rx_pid,
    input  logic       pkt_err,
    input  logic       xfer_done,
    input  logic       glob_np_in_nak,
    input  logic       glob_out_nak,
    output logic       hs_ack,
    output logic       hs_nak,
    output logic       hs_stall,
    output logic       zlp_req,
    output logic       send_data,
    output logic       store_data,
    output logic       exp_pid,
    output logic       frame_odd,
    output logic       nak_status
);

    logic      nak_q;
    logic      stall_q;
    logic      snoop_q;
    ep_kind_e  type_q;
    logic      pid_q;
    logic      odd_q;
    hs_state_e nxt_st;
    logic      pid_toggle;
    logic      setup_seen;
    logic      hw_nak_set;
    hs_resp_t  resp;

    assign hw_nak_set = setup_seen || xfer_done;

    ep_hs_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_stall   (cfg_stall),
        .cfg_snoop   (cfg_snoop),
        .cfg_type    (ep_kind_e'(cfg_type)),
        .set_nak     (set_nak),
        .clr_nak     (clr_nak),
        .set_even_d0 (set_even_d0),
        .set_odd_d1  (set_odd_d1),
        .hw_nak_set  (hw_nak_set),
        .setup_seen  (setup_seen),
        .pid_toggle  (pid_toggle),
        .nak_q       (nak_q),
        .stall_q     (stall_q),
        .snoop_q     (snoop_q),
        .type_q      (type_q),
        .pid_q       (pid_q),
        .odd_q       (odd_q)
    );

    ep_hs_decide u_decide (
        .tok_valid      (tok_valid),
        .tok_kind       (tok_kind_e'(tok_kind)),
        .ep_type        (type_q),
        .nak            (nak_q),
        .stall          (stall_q),
        .snoop          (snoop_q),
        .fifo_space     (fifo_space),
        .tx_avail       (tx_avail),
        .rx_pid         (rx_pid),
        .pkt_err        (pkt_err),
        .exp_pid        (pid_q),
        .glob_np_in_nak (glob_np_in_nak),
        .glob_out_nak   (glob_out_nak),
        .nxt_st         (nxt_st),
        .pid_toggle     (pid_toggle),
        .setup_seen     (setup_seen)
    );

    ep_hs_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_st (nxt_st),
        .resp   (resp)
    );

    assign hs_ack     = resp.ack;
    assign hs_nak     = resp.nak;
    assign hs_stall   = resp.stall;
    assign zlp_req    = resp.zlp;
    assign send_data  = resp.send;
    assign store_data = resp.store;
    assign exp_pid    = pid_q;
    assign frame_odd  = odd_q;
    assign nak_status = nak_q;

    p_setup_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TK_SETUP) |=> (hs_ack && store_data))
        else $error("R4: SETUP not acknowledged");

    p_hw_nak_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done || (tok_valid && tok_kind == TK_SETUP)) |=> nak_status)
        else $error("R3: hardware did not set NAK");

    p_stall_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind[1] && stall_q &&
         (type_q == EP_BULK || type_q == EP_INTR)) |=> hs_stall)
        else $error("R5: halted endpoint did not stall");

    p_iso_zlp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TK_IN && type_q == EP_ISO && nak_q) |=> zlp_req)
        else $error("R7: isochronous IN under NAK without zero-length packet");

endmodule

// File: tb/ep_handshake_ctrl_test.sv
`timescale 1ns/1ps
module ep_handshake_ctrl_test;

    localparam logic [5:0] E_NONE  = 6'b000000;
    localparam logic [5:0] E_ACKST = 6'b100001;
    localparam logic [5:0] E_ACKDR = 6'b100000;
    localparam logic [5:0] E_NAK   = 6'b010000;
    localparam logic [5:0] E_STALL = 6'b001000;
    localparam logic [5:0] E_ZLP   = 6'b000100;
    localparam logic [5:0] E_SEND  = 6'b000010;
    localparam logic [5:0] E_STORE = 6'b000001;

    localparam logic [1:0] K_SETUP = 2'b01;
    localparam logic [1:0] K_OUT   = 2'b10;
    localparam logic [1:0] K_IN    = 2'b11;

    localparam logic [1:0] T_CTRL = 2'b00;
    localparam logic [1:0] T_ISO  = 2'b01;
    localparam logic [1:0] T_BULK = 2'b10;
    localparam logic [1:0] T_INTR = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_stall = 0, cfg_snoop = 0;
    logic [1:0] cfg_type = 2'b00;
    logic set_nak = 0, clr_nak = 0, set_even_d0 = 0, set_odd_d1 = 0;
    logic tok_valid = 0;
    logic [1:0] tok_kind = 2'b00;
    logic fifo_space = 0, tx_avail = 0, rx_pid = 0, pkt_err = 0, xfer_done = 0;
    logic glob_np_in_nak = 0, glob_out_nak = 0;
    logic hs_ack, hs_nak, hs_stall, zlp_req, send_data, store_data;
    logic exp_pid, frame_odd, nak_status;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [5:0] exp;
        int         due;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    ep_handshake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stall(cfg_stall),
        .cfg_snoop(cfg_snoop), .cfg_type(cfg_type), .set_nak(set_nak),
        .clr_nak(clr_nak), .set_even_d0(set_even_d0), .set_odd_d1(set_odd_d1),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .fifo_space(fifo_space),
        .tx_avail(tx_avail), .rx_pid(rx_pid), .pkt_err(pkt_err),
        .xfer_done(xfer_done), .glob_np_in_nak(glob_np_in_nak),
        .glob_out_nak(glob_out_nak), .hs_ack(hs_ack), .hs_nak(hs_nak),
        .hs_stall(hs_stall), .zlp_req(zlp_req), .send_data(send_data),
        .store_data(store_data), .exp_pid(exp_pid), .frame_odd(frame_odd),
        .nak_status(nak_status)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares responses when they fall due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            logic [5:0] got;
            it  = sb_q.pop_front();
            got = {hs_ack, hs_nak, hs_stall, zlp_req, send_data, store_data};
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s response got=%b exp=%b", it.tag, got, it.exp);
            end
        end
    end

    task automatic clear_drive();
        cfg_we = 0; set_nak = 0; clr_nak = 0; set_even_d0 = 0; set_odd_d1 = 0;
        xfer_done = 0; tok_valid = 0; pkt_err = 0;
    endtask

    task automatic push(input logic [5:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.due = cyc + 1;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        clear_drive();
        push(E_NONE, "R13");
    endtask

    task automatic tok(input logic [1:0] k, input logic sp, input logic av,
                       input logic pid, input logic err,
                       input logic [5:0] e, input string tag);
        @(negedge clk);
        clear_drive();
        tok_valid = 1; tok_kind = k; fifo_space = sp; tx_avail = av;
        rx_pid = pid; pkt_err = err;
        push(e, tag);
    endtask

    // bits: {set_nak, clr_nak, set_even_d0, set_odd_d1, xfer_done}
    task automatic strobe(input logic [4:0] s);
        @(negedge clk);
        clear_drive();
        {set_nak, clr_nak, set_even_d0, set_odd_d1, xfer_done} = s;
        push(E_NONE, "R13");
        idle();
    endtask

    task automatic cfg(input logic [1:0] t, input logic st, input logic sn);
        @(negedge clk);
        clear_drive();
        cfg_we = 1; cfg_type = t; cfg_stall = st; cfg_snoop = sn;
        push(E_NONE, "R13");
        idle();
    endtask

    task automatic chk_state(input logic n, input logic p, input logic o,
                             input string tag);
        checks++;
        if ({nak_status, exp_pid, frame_odd} !== {n, p, o}) begin
            failures++;
            $display("FAIL %s state nak/pid/odd got=%b%b%b exp=%b%b%b", tag,
                     nak_status, exp_pid, frame_odd, n, p, o);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk_state(0, 0, 0, "R1");
        checks++;
        if ({hs_ack, hs_nak, hs_stall, zlp_req, send_data, store_data} !== E_NONE) begin
            failures++;
            $display("FAIL R1 response got=%b exp=%b",
                     {hs_ack, hs_nak, hs_stall, zlp_req, send_data, store_data}, E_NONE);
        end

        // bulk: PID forcing (R10)
        cfg(T_BULK, 0, 0);
        strobe(5'b00010); chk_state(0, 1, 0, "R10");
        strobe(5'b00100); chk_state(0, 0, 0, "R10");

        // R8 toggle / mismatch
        tok(K_OUT, 1, 0, 0, 0, E_ACKST, "R8"); idle(); chk_state(0, 1, 0, "R8");
        tok(K_OUT, 1, 0, 0, 0, E_ACKDR, "R8"); idle(); chk_state(0, 1, 0, "R8");
        // R9 error without snoop, then with snoop
        tok(K_OUT, 1, 0, 1, 1, E_NONE, "R9"); idle(); chk_state(0, 1, 0, "R9");
        cfg(T_BULK, 0, 1);
        tok(K_OUT, 1, 0, 1, 1, E_ACKST, "R9"); idle(); chk_state(0, 0, 0, "R9");
        cfg(T_BULK, 0, 0);

        // R11 FIFO conditions, back-to-back (R13)
        tok(K_OUT, 0, 0, 0, 0, E_NAK, "R11");
        tok(K_IN, 0, 1, 0, 0, E_SEND, "R11");
        tok(K_IN, 0, 0, 0, 0, E_NAK, "R11");
        idle(); chk_state(0, 0, 0, "R11");

        // R2 / R12 / R6 / R7 under local NAK
        strobe(5'b10000); chk_state(1, 0, 0, "R12");
        tok(K_OUT, 1, 0, 0, 0, E_NAK, "R6");
        tok(K_IN, 0, 1, 0, 0, E_NAK, "R7");
        idle();
        strobe(5'b01000); chk_state(0, 0, 0, "R2");
        strobe(5'b11000); chk_state(1, 0, 0, "R2");
        strobe(5'b01000); chk_state(0, 0, 0, "R2");

        // global NAKs
        glob_out_nak = 1;
        tok(K_OUT, 1, 0, 0, 0, E_NAK, "R6");
        idle();
        glob_out_nak = 0; glob_np_in_nak = 1;
        tok(K_IN, 0, 1, 0, 0, E_NAK, "R7");
        idle();

        // R5 STALL priority with all NAKs active
        cfg(T_BULK, 1, 0);
        strobe(5'b10000);
        glob_out_nak = 1;
        tok(K_OUT, 1, 0, 0, 0, E_STALL, "R5");
        tok(K_IN, 0, 1, 0, 0, E_STALL, "R5");
        idle();
        glob_out_nak = 0; glob_np_in_nak = 0;
        strobe(5'b01000);

        // R4 SETUP on halted endpoint, R3 hardware NAK and PID load
        glob_out_nak = 1; glob_np_in_nak = 1;
        tok(K_SETUP, 0, 0, 0, 0, E_ACKST, "R4");
        idle(); chk_state(1, 1, 0, "R3");
        glob_out_nak = 0; glob_np_in_nak = 0;
        strobe(5'b00001);
        tok(K_OUT, 1, 0, 1, 0, E_STALL, "R5");
        idle();
        cfg(T_BULK, 0, 0);
        tok(K_OUT, 1, 0, 1, 0, E_NAK, "R6");
        idle();
        strobe(5'b01000); chk_state(0, 1, 0, "R2");
        strobe(5'b00001); chk_state(1, 1, 0, "R3");
        strobe(5'b01000);

        // isochronous: STALL ignored, parity forcing, ZLP
        cfg(T_ISO, 1, 0);
        strobe(5'b00010); chk_state(0, 1, 1, "R10");
        strobe(5'b00100); chk_state(0, 1, 0, "R10");
        tok(K_IN, 0, 1, 0, 0, E_SEND, "R5");
        tok(K_IN, 0, 0, 0, 0, E_ZLP, "R11");
        tok(K_OUT, 1, 0, 0, 0, E_STORE, "R11");
        tok(K_OUT, 1, 0, 0, 1, E_NONE, "R9");
        tok(K_OUT, 0, 0, 0, 0, E_NONE, "R11");
        idle();
        strobe(5'b10000);
        tok(K_IN, 0, 1, 0, 0, E_ZLP, "R7");
        tok(K_OUT, 1, 0, 0, 0, E_NONE, "R6");
        idle();
        strobe(5'b01000);
        glob_np_in_nak = 1;
        tok(K_IN, 0, 1, 0, 0, E_SEND, "R7");
        idle();
        glob_np_in_nak = 0;

        // control: STALL and force strobes have no effect
        cfg(T_CTRL, 1, 0);
        tok(K_IN, 0, 1, 0, 0, E_SEND, "R5");
        idle();
        strobe(5'b00100); chk_state(0, 1, 0, "R10");
        tok(K_OUT, 1, 0, 1, 0, E_ACKST, "R8");
        idle(); chk_state(0, 0, 0, "R8");

        // interrupt: global non-periodic IN NAK ignored, STALL honoured
        cfg(T_INTR, 0, 0);
        glob_np_in_nak = 1;
        tok(K_IN, 0, 1, 0, 0, E_SEND, "R7");
        idle();
        glob_np_in_nak = 0;
        cfg(T_INTR, 1, 0);
        tok(K_IN, 0, 1, 0, 0, E_STALL, "R5");
        idle();
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule